// File: doc/BRIEF.md
# Privilege-filtered event counter with overflow interrupt

This block is one slice of a hardware performance monitor. It holds a 64-bit event counter and a 64-bit event selector. Each cycle in which the event input is high, the counter goes up by one, unless the selector has masked the hart's current privilege mode. Each of the five privilege modes (machine, supervisor, user, virtual supervisor, virtual user) has its own mask bit. When all five mask bits are clear, events are counted in every mode.

When a counted event carries the counter from all-ones back to zero, the selector's overflow flag is set. The flag is sticky and is cleared only by a selector write. The slice also raises a local counter-overflow interrupt request. The surrounding logic reports this request at bit position 13 of the interrupt-pending and interrupt-enable registers.

Software reads and writes both registers through a plain register port. The counter accepts any 64-bit value. Event-source selection, CSR address decode and trap handling are outside this block.

Top module: `pmc_slice`

## Requirements
- R1: After reset, the counter reads 0, the selector reads 0 and the interrupt output is low.
- R2: When no mask bit is set, an event in any of the mode codes 0 (machine), 1 (supervisor), 2 (user), 3 (virtual supervisor) and 4 (virtual user) raises the counter by one in the next cycle.
- R3: Selector bits 62, 61, 60, 59 and 58 mask modes 0, 1, 2, 3 and 4, in that order. An event that arrives while the current mode's mask bit is 1 leaves the counter unchanged.
- R4: Mode codes 5, 6 and 7 are never counted.
- R5: Selector bits 57 and 56 always read 0, whatever is written to them. Bits 55:0 hold the event-select code and read back as written.
- R6: A counter write stores all 64 bits of the write data. If a counted event falls in the same cycle as the counter write, the write wins and the event is dropped.
- R7: A counted event at all-ones wraps the counter to 0 and sets selector bit 63 (the overflow flag) in the same cycle.
- R8: The overflow flag stays set until a selector write puts 0 in bit 63. If an overflow occurs in the same cycle as such a write, the flag still ends up set.
- R9: The interrupt output pulses high for exactly one cycle. The pulse appears together with the overflow flag, and only when the flag was clear before the overflow. An overflow while the flag is already set raises no pulse. Setting the flag by software raises no pulse.
- R10: With the event input low and no counter write, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cnt_we_i | input | 1 | Write wdata_i into the counter |
| sel_we_i | input | 1 | Write wdata_i into the selector |
| wdata_i | input | 64 | Shared write data |
| priv_mode_i | input | 3 | Current privilege mode code |
| event_i | input | 1 | Event occurred this cycle |
| cnt_rdata_o | output | 64 | Counter value |
| sel_rdata_o | output | 64 | Selector value |
| ovf_irq_o | output | 1 | Overflow interrupt request pulse |

## Verification
Two pairs of actions can land in the same cycle.

- **Counter write with a counted event.** The bench provokes this by writing the counter while holding the event high in an unmasked mode. The check is that the written value, not the value plus one, reads back.
- **Selector write with an overflow.** The bench writes bit 63 to zero while a counted event wraps the counter. The check is that the flag stays set and that an interrupt pulse appears only when the flag was clear beforehand.

A behavioural model compares the counter, the selector and the interrupt every cycle. The comparison runs through these directed collisions and through a long stretch of random traffic in which counter writes cluster just below all-ones.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int unsigned SEL_W     = 64;
    localparam int unsigned NUM_MODES = 5;
    localparam int unsigned MODE_W    = 3;
    localparam int unsigned CODE_W    = 56;

    typedef enum logic [MODE_W-1:0] {
        PRIV_MACH  = 3'd0,
        PRIV_SUPV  = 3'd1,
        PRIV_USER  = 3'd2,
        PRIV_VSUPV = 3'd3,
        PRIV_VUSER = 3'd4
    } priv_mode_e;

endpackage

// File: rtl/pmc_mode_gate.sv
module pmc_mode_gate #(
    parameter int unsigned N_MODES = pmc_pkg::NUM_MODES,
    parameter int unsigned MODE_W  = pmc_pkg::MODE_W
) (
    input  logic [MODE_W-1:0]  mode_i,
    input  logic [N_MODES-1:0] mask_i,
    output logic               allow_o
);

    // One term per supported mode; codes outside the range match none.
    logic [N_MODES-1:0] hit;

    for (genvar k = 0; k < N_MODES; k++) begin : g_mode
        assign hit[k] = (mode_i == MODE_W'(k)) && !mask_i[k];
    end

    assign allow_o = |hit;

endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] value_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] val;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = 1'b0;
        if (wr_en_i) begin
            // Software write wins; a coincident event is dropped.
            st_d.val = wr_data_i;
        end else if (inc_i) begin
            st_d.val = st_q.val + ONE;
            wrap_o   = &st_q.val;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value_o = st_q.val;

endmodule

// File: rtl/pmc_selector.sv
module pmc_selector #(
    parameter int unsigned SEL_W   = pmc_pkg::SEL_W,
    parameter int unsigned N_MODES = pmc_pkg::NUM_MODES,
    parameter int unsigned CODE_W  = pmc_pkg::CODE_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [SEL_W-1:0]   wr_data_i,
    input  logic               ovf_i,
    output logic [SEL_W-1:0]   rdata_o,
    output logic [N_MODES-1:0] mask_o,
    output logic               irq_o
);

    localparam int unsigned OF_POS   = SEL_W - 1;
    localparam int unsigned MASK_TOP = SEL_W - 2;

    typedef struct packed {
        logic               ovf;
        logic [N_MODES-1:0] mask;
        logic [CODE_W-1:0]  code;
        logic               irq;
    } sel_state_t;

    sel_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (wr_en_i) begin
            st_d.ovf  = wr_data_i[OF_POS];
            st_d.code = wr_data_i[CODE_W-1:0];
            for (int k = 0; k < int'(N_MODES); k++) begin
                st_d.mask[k] = wr_data_i[MASK_TOP-k];
            end
        end
        // Hardware overflow overrides a coincident software clear.
        if (ovf_i) begin
            st_d.ovf = 1'b1;
            st_d.irq = !st_q.ovf;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o             = '0;
        rdata_o[OF_POS]     = st_q.ovf;
        rdata_o[CODE_W-1:0] = st_q.code;
        for (int k = 0; k < int'(N_MODES); k++) begin
            rdata_o[MASK_TOP-k] = st_q.mask[k];
        end
    end

    assign mask_o = st_q.mask;
    assign irq_o  = st_q.irq;

endmodule

// File: rtl/pmc_slice.sv
module pmc_slice #(
    parameter int unsigned CNT_W  = 64,
    parameter int unsigned SEL_W  = pmc_pkg::SEL_W,
    parameter int unsigned CODE_W = pmc_pkg::CODE_W
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       cnt_we_i,
    input  logic                       sel_we_i,
    input  logic [SEL_W-1:0]           wdata_i,
    input  logic [pmc_pkg::MODE_W-1:0] priv_mode_i,
    input  logic                       event_i,
    output logic [CNT_W-1:0]           cnt_rdata_o,
    output logic [SEL_W-1:0]           sel_rdata_o,
    output logic                       ovf_irq_o
);

    localparam int unsigned N_MODES = pmc_pkg::NUM_MODES;

    logic [N_MODES-1:0] mode_mask;
    logic               mode_allow;
    logic               count_inc;
    logic               cnt_wrap;

    pmc_mode_gate #(
        .N_MODES (N_MODES),
        .MODE_W  (pmc_pkg::MODE_W)
    ) gate_i (
        .mode_i  (priv_mode_i),
        .mask_i  (mode_mask),
        .allow_o (mode_allow)
    );

    assign count_inc = event_i && mode_allow;

    pmc_counter #(
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (cnt_we_i),
        .wr_data_i (wdata_i[CNT_W-1:0]),
        .inc_i     (count_inc),
        .value_o   (cnt_rdata_o),
        .wrap_o    (cnt_wrap)
    );

    pmc_selector #(
        .SEL_W   (SEL_W),
        .N_MODES (N_MODES),
        .CODE_W  (CODE_W)
    ) sel_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (sel_we_i),
        .wr_data_i (wdata_i),
        .ovf_i     (cnt_wrap),
        .rdata_o   (sel_rdata_o),
        .mask_o    (mode_mask),
        .irq_o     (ovf_irq_o)
    );

endmodule

// File: rtl/pmc_slice_chk.sv
module pmc_slice_chk #(
    parameter int unsigned CNT_W = 64,
    parameter int unsigned SEL_W = 64
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             cnt_we_i,
    input logic             sel_we_i,
    input logic [SEL_W-1:0] wdata_i,
    input logic [2:0]       priv_mode_i,
    input logic             event_i,
    input logic [CNT_W-1:0] cnt_rdata_o,
    input logic [SEL_W-1:0] sel_rdata_o,
    input logic             ovf_irq_o
);

    logic blocked;
    always_comb begin
        if (priv_mode_i < 3'd5) begin
            blocked = sel_rdata_o[SEL_W - 2 - int'(priv_mode_i)];
        end else begin
            blocked = 1'b1;
        end
    end

    // R1
    p_reset_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (cnt_rdata_o == '0 && sel_rdata_o == '0 && !ovf_irq_o));

    p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!event_i && !cnt_we_i) |=> $stable(cnt_rdata_o));

    // R3 and R4: masked or unsupported modes do not count
    p_blocked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (event_i && !cnt_we_i && blocked) |=> $stable(cnt_rdata_o));

    p_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (event_i && !cnt_we_i && !blocked)
            |=> cnt_rdata_o == $past(cnt_rdata_o) + CNT_W'(1));

    p_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_we_i |=> cnt_rdata_o == $past(wdata_i[CNT_W-1:0]));

    p_resv_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_rdata_o[SEL_W-7:SEL_W-8] == 2'b00);

    p_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (event_i && !cnt_we_i && !blocked && (&cnt_rdata_o))
            |=> sel_rdata_o[SEL_W-1]);

    p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_rdata_o[SEL_W-1] && !sel_we_i) |=> sel_rdata_o[SEL_W-1]);

    p_irq_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_irq_o |-> (sel_rdata_o[SEL_W-1] && !$past(sel_rdata_o[SEL_W-1])));

    p_irq_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_irq_o |=> !ovf_irq_o);

endmodule

bind pmc_slice pmc_slice_chk #(
    .CNT_W (CNT_W),
    .SEL_W (SEL_W)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_we_i    (cnt_we_i),
    .sel_we_i    (sel_we_i),
    .wdata_i     (wdata_i),
    .priv_mode_i (priv_mode_i),
    .event_i     (event_i),
    .cnt_rdata_o (cnt_rdata_o),
    .sel_rdata_o (sel_rdata_o),
    .ovf_irq_o   (ovf_irq_o)
);

// File: tb/pmc_slice_tb_top.sv
`timescale 1ns/1ps
module pmc_slice_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        cnt_we_i = 1'b0;
    logic        sel_we_i = 1'b0;
    logic [63:0] wdata_i = '0;
    logic [2:0]  priv_mode_i = '0;
    logic        event_i = 1'b0;
    logic [63:0] cnt_rdata_o;
    logic [63:0] sel_rdata_o;
    logic        ovf_irq_o;

    always #2 clk_i = ~clk_i;

    pmc_slice dut_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cnt_we_i    (cnt_we_i),
        .sel_we_i    (sel_we_i),
        .wdata_i     (wdata_i),
        .priv_mode_i (priv_mode_i),
        .event_i     (event_i),
        .cnt_rdata_o (cnt_rdata_o),
        .sel_rdata_o (sel_rdata_o),
        .ovf_irq_o   (ovf_irq_o)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;
    string cur_req  = "R1";

    // Behavioural reference state
    longint unsigned m_cnt  = 0;
    bit              m_of   = 0;
    bit [4:0]        m_mask = '0;
    bit [55:0]       m_code = '0;
    bit              m_irq  = 0;

    function automatic logic [63:0] exp_sel();
        logic [63:0] e = '0;
        e[63] = m_of;
        for (int k = 0; k < 5; k++) e[62-k] = m_mask[k];
        e[55:0] = m_code;
        return e;
    endfunction

    task automatic check64(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check64("counter", cnt_rdata_o, 64'(m_cnt));
        check64("selector", sel_rdata_o, exp_sel());
        check64("irq", {63'd0, ovf_irq_o}, {63'd0, m_irq});
    endtask

    // Drive one cycle at a falling edge, advance the model, compare at the next falling edge
    task automatic cyc(input bit ev, input bit [2:0] md, input bit cw, input bit sw,
                       input logic [63:0] wd);
        bit counted, wrap;
        event_i     = ev;
        priv_mode_i = md;
        cnt_we_i    = cw;
        sel_we_i    = sw;
        wdata_i     = wd;
        counted = ev && (md < 3'd5) && !m_mask[md];
        wrap    = counted && !cw && (m_cnt == 64'hFFFF_FFFF_FFFF_FFFF);
        @(posedge clk_i);
        m_irq = wrap && !m_of;
        if (cw)           m_cnt = wd;
        else if (counted) m_cnt = m_cnt + 1;
        if (sw) begin
            m_of = wd[63];
            for (int k = 0; k < 5; k++) m_mask[k] = wd[62-k];
            m_code = wd[55:0];
        end
        if (wrap) m_of = 1'b1;
        @(negedge clk_i);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 3'd0, 0, 0, '0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk_i);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        cur_req = "R1";
        compare_all();
        rst_ni = 1'b1;

        cur_req = "R10";
        cyc(0, 3'd0, 0, 0, '0);
        cyc(0, 3'd3, 0, 0, 64'h1234);
        idle(2);

        cur_req = "R2";
        for (int m = 0; m < 5; m++) cyc(1, 3'(m), 0, 0, '0);

        cur_req = "R5";
        cyc(0, 3'd0, 0, 1, 64'h03FF_FFFF_FFFF_FFFF);  // reserved bits set, all else masked off
        cyc(0, 3'd0, 0, 1, 64'h0300_0000_00AB_CDEF);
        cyc(0, 3'd0, 0, 1, 64'h0000_0000_0000_0000);

        cur_req = "R3";
        for (int k = 0; k < 5; k++) begin
            logic [63:0] w = '0;
            w[62-k] = 1'b1;
            cyc(0, 3'd0, 0, 1, w);
            for (int m = 0; m < 5; m++) cyc(1, 3'(m), 0, 0, '0);
        end
        cyc(0, 3'd0, 0, 1, 64'h7C00_0000_0000_0000);
        for (int m = 0; m < 5; m++) cyc(1, 3'(m), 0, 0, '0);
        cyc(0, 3'd0, 0, 1, '0);

        cur_req = "R4";
        for (int m = 5; m < 8; m++) cyc(1, 3'(m), 0, 0, '0);

        cur_req = "R6";
        cyc(0, 3'd0, 1, 0, 64'hDEAD_BEEF_0123_4567);
        cyc(1, 3'd2, 1, 0, 64'h0000_0000_0000_0010);  // event dropped
        cyc(1, 3'd2, 0, 0, '0);

        cur_req = "R7";
        cyc(0, 3'd0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFE);
        cyc(1, 3'd1, 0, 0, '0);
        cyc(1, 3'd1, 0, 0, '0);  // wraps here
        cur_req = "R9";
        cyc(0, 3'd0, 0, 0, '0);  // pulse must be gone
        cyc(0, 3'd0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        cyc(1, 3'd0, 0, 0, '0);  // wrap while flag set: no pulse

        cur_req = "R8";
        idle(3);
        cyc(0, 3'd0, 0, 1, '0);  // clear flag
        cyc(0, 3'd0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        cyc(1, 3'd4, 0, 1, '0);  // clear and wrap together: flag set, pulse
        cyc(0, 3'd0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        cyc(1, 3'd4, 0, 1, '0);  // flag already set: stays, no pulse
        cur_req = "R9";
        cyc(0, 3'd0, 0, 1, '0);
        cyc(0, 3'd0, 0, 1, 64'h8000_0000_0000_0000);  // software set, no pulse
        cyc(0, 3'd0, 0, 1, '0);

        cur_req = "R7";
        for (int i = 0; i < 4000; i++) begin
            int unsigned r = $urandom;
            bit cw = (r[3:0] == 4'd0);
            bit sw = (r[7:4] == 4'd0);
            logic [63:0] wd;
            if (cw) wd = 64'hFFFF_FFFF_FFFF_FFF0 | 64'(r[11:8]);
            else    wd = {r[31], 1'b0, r[30:28] == 3'd0 ? 5'b0 : 5'(r[20:16]), 57'(r[27:12])};
            cyc(r[24] | r[25], 3'(r[23:21]), cw, sw, wd);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule